// File: doc/BRIEF.md
# Peripheral Interrupt Controller with Hidden Trigger Latch

This block gathers up to eight interrupt inputs belonging to a single peripheral. Software configures it through a byte-wide register port. For each source, software selects a trigger mode and polarity, sets or clears the enable, reads the visible latched status and clears the latch. Whenever a visible latched bit goes from 0 to 1, the block sends a one-cycle notification pulse toward the host bus.

Every source also has an internal latch that software cannot read. A qualifying trigger condition sets this latch whatever the enable state, and while the source is disabled nothing else happens. When the source is later enabled with this latch still set, the latch moves into the visible status and a notification goes out. Software that wants to avoid this clears the latch first. The latch-clear register sits one address below the enable-set register, so one two-byte auto-incrementing write does both steps in order.

The register port works as follows. A start cycle loads an address pointer. Each later write cycle updates the register under the pointer and then advances the pointer by one. Read data always shows the register under the pointer.

Top module: `perif_irq_ctl`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_notify` is low.
- R2: The trigger condition depends on mode bit i at address 1 (0 = level, 1 = edge) and on the high-polarity (address 2) and low-polarity (address 3) bits. In level mode, the high bit selects input high as active and the low bit selects input low as active. In edge mode, the high bit selects rising edges and the low bit selects falling edges, and both bits may be set at once.
- R3: While source i is disabled, its trigger condition sets only the hidden latch. The visible latched bit (address 4) stays 0, the status bit (address 0) stays 0 and no notification is produced.
- R4: Setting the enable of a source whose hidden latch is set sets its visible latched bit and raises `irq_notify`. Both happen one clock after the enable is registered.
- R5: Writing 1 to bit i at address 5 clears both the hidden latch and the visible latched bit of source i. Bits written as 0 have no effect, and address 5 reads 0x00.
- R6: A write burst auto-increments the address pointer. Writing two bytes starting at address 5 clears the latch and then enables the source, and no notification follows.
- R7: Writing 1 to bit i at address 6 sets enable i, and writing 1 at address 7 clears it. A 0 bit changes nothing. Both addresses read back the current enable bits.
- R8: A level-mode source whose input is still active after its latch is cleared latches again on the next cycle. If it is enabled, it produces a new notification.
- R9: `irq_notify` is high for exactly one clock for every clock in which one or more visible latched bits rise. Address 0 reads the bitwise AND of the visible latched bits and the enable bits.
- R10: Bit position i of every register belongs to source i. Addresses 1, 2 and 3 read back the value last written to them. Writes to the read-only addresses 0 and 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Interrupt inputs, synchronous to clk |
| bus_start | input | 1 | Loads the address pointer from bus_addr |
| bus_addr | input | 3 | Start address of a transfer |
| bus_wr | input | 1 | Writes bus_wdata at the pointer, then advances the pointer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Contents of the register under the pointer |
| irq_notify | output | 1 | One-cycle notification pulse |

## Verification
The bench targets these corner cases:
- An edge that arrives while its source is disabled. A design that updated the visible status at that moment would pulse the notification too early. One that forgot the hidden latch would never pulse when the source is later enabled.
- The two-byte clear-then-enable burst. Letting the enable take effect before the clear, or failing to advance the pointer, would produce a spurious notification or leave the source disabled.
- A level input that is still held high when its latch is cleared. This must re-latch and notify again. A design that gave the clear lasting priority would lose this interrupt.
- Random configuration, input and register traffic, checked cycle by cycle against a bench model of the requirements. A notification that is missing, doubled or stretched shows up here.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned NREG   = 1 << ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT  = 3'd0,
        A_MODE  = 3'd1,
        A_POLH  = 3'd2,
        A_POLL  = 3'd3,
        A_LATCH = 3'd4,
        A_LCLR  = 3'd5,
        A_ENSET = 3'd6,
        A_ENCLR = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/pic_bus.sv
module pic_bus
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    output logic [NREG-1:0]   wr_stb,
    output logic [ADDR_W-1:0] ptr
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic    wr_go;

    always_comb begin
        st_d  = st_q;
        wr_go = bus_wr && !bus_start;
        if (bus_start) begin
            st_d.ptr = bus_addr;
        end else if (bus_wr) begin
            st_d.ptr = ADDR_W'(st_q.ptr + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar a = 0; a < NREG; a++) begin : g_stb
        assign wr_stb[a] = wr_go && (st_q.ptr == ADDR_W'(a));
    end

    assign ptr = st_q.ptr;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_start) |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R6
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb)); // R10
endmodule

// File: rtl/pic_detect.sv
module pic_detect #(
    parameter int unsigned NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] mode,
    input  logic [NSRC-1:0] pol_h,
    input  logic [NSRC-1:0] pol_l,
    output logic [NSRC-1:0] hit
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic lvl_hit, edg_hit;
        assign lvl_hit = (pol_h[i] && src[i]) || (pol_l[i] && !src[i]);
        assign edg_hit = (pol_h[i] && src[i] && !st_q.prev[i])
                      || (pol_l[i] && !src[i] && st_q.prev[i]);
        assign hit[i]  = mode[i] ? edg_hit : lvl_hit;

        AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] && hit[i]) |-> (src[i] != st_q.prev[i])); // R2
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int unsigned NSRC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   hit,
    input  logic [NREG-1:0]   wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   mode,
    output logic [NSRC-1:0]   pol_h,
    output logic [NSRC-1:0]   pol_l,
    output logic [NSRC-1:0]   en,
    output logic [NSRC-1:0]   vis,
    output logic              notify
);
    typedef struct packed {
        logic [NSRC-1:0] mode;
        logic [NSRC-1:0] pol_h;
        logic [NSRC-1:0] pol_l;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] hid;
        logic [NSRC-1:0] vis;
        logic            ntf;
    } core_st_t;

    core_st_t        st_d, st_q;
    logic [NSRC-1:0] wb, set_m, clr_m, lclr_m;

    always_comb begin
        st_d   = st_q;
        wb     = wdata[NSRC-1:0];
        set_m  = wr_stb[A_ENSET] ? wb : '0;
        clr_m  = wr_stb[A_ENCLR] ? wb : '0;
        lclr_m = wr_stb[A_LCLR]  ? wb : '0;
        if (wr_stb[A_MODE]) st_d.mode  = wb;
        if (wr_stb[A_POLH]) st_d.pol_h = wb;
        if (wr_stb[A_POLL]) st_d.pol_l = wb;
        st_d.en  = (st_q.en | set_m) & ~clr_m;
        st_d.hid = (st_q.hid | hit) & ~lclr_m;
        st_d.vis = (st_q.vis | (st_q.hid & st_q.en)) & ~lclr_m;
        st_d.ntf = |(st_d.vis & ~st_q.vis);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode   = st_q.mode;
    assign pol_h  = st_q.pol_h;
    assign pol_l  = st_q.pol_l;
    assign en     = st_q.en;
    assign vis    = st_q.vis;
    assign notify = st_q.ntf;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        AST_NO_SET_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (vis[i] && !$past(vis[i])) |-> $past(en[i])); // R3
        AST_LCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb[A_LCLR] && wdata[i]) |=> (!st_q.hid[i] && !vis[i])); // R5
        AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb[A_ENSET] && wdata[i]) |=> en[i]); // R7
        AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb[A_ENCLR] && wdata[i]) |=> !en[i]); // R7
    end

    AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> ((vis & ~$past(vis)) != '0)); // R9
    AST_NOTIFY_EACH: assert property (@(posedge clk) disable iff (!rst_n)
        ((vis & ~$past(vis)) != '0) |-> notify); // R9
endmodule

// File: rtl/perif_irq_ctl.sv
module perif_irq_ctl
    import pic_pkg::*;
#(
    parameter int unsigned NSRC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              bus_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_notify
);
    logic [NREG-1:0]   wr_stb;
    logic [ADDR_W-1:0] ptr;
    logic [NSRC-1:0]   hit, mode, pol_h, pol_l, en, vis;

    pic_bus i_bus (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .wr_stb(wr_stb), .ptr(ptr)
    );

    pic_detect #(.NSRC(NSRC)) i_detect (
        .clk(clk), .rst_n(rst_n), .src(irq_src), .mode(mode),
        .pol_h(pol_h), .pol_l(pol_l), .hit(hit)
    );

    pic_core #(.NSRC(NSRC)) i_core (
        .clk(clk), .rst_n(rst_n), .hit(hit), .wr_stb(wr_stb), .wdata(bus_wdata),
        .mode(mode), .pol_h(pol_h), .pol_l(pol_l), .en(en), .vis(vis),
        .notify(irq_notify)
    );

    always_comb begin
        unique case (reg_addr_e'(ptr))
            A_STAT:  bus_rdata = DATA_W'(vis & en);
            A_MODE:  bus_rdata = DATA_W'(mode);
            A_POLH:  bus_rdata = DATA_W'(pol_h);
            A_POLL:  bus_rdata = DATA_W'(pol_l);
            A_LATCH: bus_rdata = DATA_W'(vis);
            A_LCLR:  bus_rdata = '0;
            A_ENSET: bus_rdata = DATA_W'(en);
            A_ENCLR: bus_rdata = DATA_W'(en);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/test_perif_irq_ctl.sv
module test_perif_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] srcs = '0;
    logic       start = 1'b0, wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       notify;

    int total = 0, bad = 0, ntf_cnt = 0;

    // bench model of the requirements
    logic [7:0] m_mode, m_ph, m_pl, m_en, m_hid, m_vis, m_prev;
    logic [2:0] m_ptr;
    logic       m_ntf;

    perif_irq_ctl #(.NSRC(8)) i_perif_irq_ctl (
        .clk(clk), .rst_n(rst_n), .irq_src(srcs), .bus_start(start),
        .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_notify(notify)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] cond_of(logic [7:0] s, logic [7:0] p,
        logic [7:0] md, logic [7:0] h, logic [7:0] l);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (md[i]) r[i] = (h[i] & s[i] & ~p[i]) | (l[i] & ~s[i] & p[i]);
            else       r[i] = (h[i] & s[i]) | (l[i] & ~s[i]);
        end
        return r;
    endfunction

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_vis & m_en;
            3'd1: return m_mode;
            3'd2: return m_ph;
            3'd3: return m_pl;
            3'd4: return m_vis;
            3'd6, 3'd7: return m_en;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= '0; m_ph <= '0; m_pl <= '0; m_en <= '0;
            m_hid <= '0; m_vis <= '0; m_prev <= '0; m_ptr <= '0; m_ntf <= 1'b0;
        end else begin
            logic [7:0] c, st, cl, lc, vn;
            logic       go;
            go = wr && !start;
            st = (go && m_ptr == 3'd6) ? wdata : 8'h00;
            cl = (go && m_ptr == 3'd7) ? wdata : 8'h00;
            lc = (go && m_ptr == 3'd5) ? wdata : 8'h00;
            c  = cond_of(srcs, m_prev, m_mode, m_ph, m_pl);
            if (go && m_ptr == 3'd1) m_mode <= wdata;
            if (go && m_ptr == 3'd2) m_ph <= wdata;
            if (go && m_ptr == 3'd3) m_pl <= wdata;
            m_en  <= (m_en | st) & ~cl;
            m_hid <= (m_hid | c) & ~lc;
            vn     = (m_vis | (m_hid & m_en)) & ~lc;
            m_vis <= vn;
            m_ntf <= |(vn & ~m_vis);
            m_prev <= srcs;
            if (start) m_ptr <= addr;
            else if (wr) m_ptr <= m_ptr + 3'd1;
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // R9: notification compared to the model every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (notify) ntf_cnt++;
            chk("R9 notify", int'(notify), int'(m_ntf));
        end
    end

    task automatic wr1(logic [2:0] a, logic [7:0] d);
        @(negedge clk); start = 1'b1; addr = a;
        @(negedge clk); start = 1'b0; wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic wr2(logic [2:0] a, logic [7:0] d0, logic [7:0] d1);
        @(negedge clk); start = 1'b1; addr = a;
        @(negedge clk); start = 1'b0; wr = 1'b1; wdata = d0;
        @(negedge clk); wdata = d1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk); start = 1'b1; addr = a;
        @(negedge clk); start = 1'b0; d = rdata;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int base;
        void'($urandom(32'h5eed_1234));
        idle(3);
        chk("R1 notify at reset", int'(notify), 0);
        rst_n = 1'b1;
        idle(2);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset value", v, 0);
        end

        // R2 R3: source 0 rising edge while disabled
        wr1(3'd1, 8'h01);
        wr1(3'd2, 8'h01);
        base = ntf_cnt;
        @(negedge clk); srcs[0] = 1'b1;
        @(negedge clk); srcs[0] = 1'b0;
        idle(3);
        rd(3'd4, v); chk("R3 latched stays 0", v, 0);
        rd(3'd0, v); chk("R3 status stays 0", v, 0);
        chk("R3 no notify", ntf_cnt - base, 0);
        // R4: enabling releases the hidden latch
        wr1(3'd6, 8'h01);
        idle(3);
        chk("R4 notify on enable", ntf_cnt - base, 1);
        rd(3'd4, v); chk("R4 latched set", v, 8'h01);
        rd(3'd0, v); chk("R9 status", v, 8'h01);
        wr1(3'd5, 8'h00);
        rd(3'd4, v); chk("R5 zero write no effect", v, 8'h01);
        wr1(3'd5, 8'h01);
        rd(3'd4, v); chk("R5 latched cleared", v, 0);
        rd(3'd5, v); chk("R5 reads zero", v, 0);

        // R6: source 1 falling edge, then clear+enable burst
        srcs[1] = 1'b1;
        wr1(3'd1, 8'h03);
        wr1(3'd3, 8'h02);
        idle(1);
        @(negedge clk); srcs[1] = 1'b0;
        idle(2);
        base = ntf_cnt;
        wr2(3'd5, 8'h02, 8'h02);
        idle(4);
        chk("R6 no spurious notify", ntf_cnt - base, 0);
        rd(3'd4, v); chk("R6 latched clear", v, 0);
        rd(3'd6, v); chk("R6 enabled", v, 8'h03);

        // R8: level source 2 held high
        wr1(3'd2, 8'h05);
        @(negedge clk); srcs[2] = 1'b1;
        idle(2);
        base = ntf_cnt;
        wr1(3'd6, 8'h04);
        idle(3);
        chk("R4 level notify", ntf_cnt - base, 1);
        wr1(3'd5, 8'h04);
        idle(4);
        chk("R8 relatch notify", ntf_cnt - base, 2);
        rd(3'd4, v); chk("R8 latched again", v, 8'h04);
        srcs[2] = 1'b0;
        idle(2);
        wr1(3'd5, 8'h04);
        idle(4);
        chk("R8 stays clear", ntf_cnt - base, 2);

        // R7 enable clear and zero writes
        wr1(3'd7, 8'h01);
        rd(3'd6, v); chk("R7 en clear", v, 8'h06);
        rd(3'd7, v); chk("R7 en clr readback", v, 8'h06);
        wr1(3'd6, 8'h00);
        wr1(3'd7, 8'h00);
        rd(3'd6, v); chk("R7 zero writes", v, 8'h06);

        // R10 readback and read-only addresses
        wr1(3'd1, 8'hA5);
        rd(3'd1, v); chk("R10 mode readback", v, 8'hA5);
        wr1(3'd0, 8'hFF);
        wr1(3'd4, 8'hFF);
        rd(3'd4, v); chk("R10 latched read-only", v, int'(m_read(3'd4)));
        rd(3'd0, v); chk("R10 status read-only", v, int'(m_read(3'd0)));

        // random phase against the model
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4) begin
                @(negedge clk); srcs = 8'($urandom);
            end else if (op < 6) begin
                wr1(3'($urandom_range(1, 7)), 8'($urandom));
            end else if (op == 6) begin
                wr2(3'($urandom_range(4, 6)), 8'($urandom), 8'($urandom));
            end else begin
                logic [2:0] ra;
                ra = 3'($urandom);
                rd(ra, v);
                chk("R2 R9 R10 random read", v, int'(m_read(ra)));
            end
        end
        idle(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule